// File: doc/BRIEF.md
# Flash Erase Timer and Status Generator

This block tracks the timing of the embedded operations of a parallel NOR flash array: sector erase, chip erase and word program. It also produces the status byte that a host polls while those operations run. A command decoder in front of it asks to start an operation. The decoder forwards the bytes written while an erase is in progress and signals each status read. The block answers with the status byte, a busy flag, a flag that says an address falls in a sector being erased, and a one-cycle completion pulse.

Sector erase has two phases. While the acceptance window is open, further sector commands can join the batch, and each one restarts the window. When the window closes, the erase timer is loaded with a duration proportional to the number of distinct sectors in the batch. An erase can be suspended and later resumed. The time still left is kept across the suspension. While suspended, the array can be read and programmed outside the marked sectors. All durations are in clock cycles and are derived from tick-rate parameters.

Top module: `flash_erase_timer`

## Requirements
- R1: After reset the status byte is 0x00, and busy, sector_hit and done are 0.
- R2: A sector erase request accepted while idle and not suspended marks its sector and clears DQ7 (bit 7) and DQ3 (bit 3). It raises busy and opens an acceptance window of WINDOW_US*TICKS_PER_US cycles.
- R3: While the window is open, a command byte 0x30 marks cmd_sector, counts it if it is new, clears DQ7 and restarts the window. Any byte other than 0x30 or 0xB0 aborts the erase: the marks are dropped, busy falls, and DQ7 and DQ3 read 0.
- R4: When the window expires, DQ3 goes to 1 and the erase runs for (distinct marked sectors)*2^SECT_EXP*TICKS_PER_MS cycles. During this phase every command byte except 0xB0 is ignored.
- R5: At erase completion the marks are cleared, DQ3 returns to 0, DQ7 toggles, busy falls and done is high for exactly one cycle.
- R6: A chip erase request clears DQ7 and stays busy for 2^CHIP_EXP*TICKS_PER_MS cycles, ignoring all command bytes. It then toggles DQ7 and pulses done.
- R7: A program request sets DQ7 to the complement of prog_bit7 for PROG_TICKS cycles. DQ7 then toggles to equal prog_bit7, and done pulses.
- R8: A status read strobe toggles DQ6 (bit 6) during a program. During the acceptance window, a sector erase or a chip erase, it toggles both DQ6 and DQ2 (bit 2). When idle and not suspended it changes nothing.
- R9: A 0xB0 byte during the window saves the full computed erase time. During the erase it saves the cycles still left (at least 1). In both cases it clears DQ3 and stops the timer, and busy falls.
- R10: While suspended and idle, sector_hit equals the mark of rd_sector. A read strobe to a marked sector toggles DQ2 only, and a read to an unmarked sector changes no status bit.
- R11: While suspended, a program request to a marked sector is dropped (DQ7 unchanged, busy stays 0). Sector erase and chip erase requests are refused. Programs to unmarked sectors run as in R7.
- R12: A 0x30 byte while suspended and idle resumes the erase: busy rises, DQ7 reads 0 and DQ3 reads 1. The erase completes as in R5 after exactly the saved number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_erase_req | input | 1 | Start a sector erase (first sector of a batch) |
| req_sector | input | $clog2(SECTORS) | Sector index of sec_erase_req |
| chip_erase_req | input | 1 | Start a chip erase |
| prog_req | input | 1 | Start a program operation |
| prog_bit7 | input | 1 | Bit 7 of the data being programmed |
| prog_sector | input | $clog2(SECTORS) | Sector targeted by the program |
| cmd_valid | input | 1 | A command byte was written during an operation or suspension |
| cmd_byte | input | 8 | The written command byte |
| cmd_sector | input | $clog2(SECTORS) | Sector addressed by the command byte |
| rd_strobe | input | 1 | A status read occurred |
| rd_sector | input | $clog2(SECTORS) | Sector addressed by the read |
| status | output | 8 | Status byte: DQ7 bit 7, DQ6 bit 6, DQ3 bit 3, DQ2 bit 2, other bits 0 |
| busy | output | 1 | An operation is running (low while suspended) |
| sector_hit | output | 1 | Suspended and rd_sector is marked for erase |
| done | output | 1 | One-cycle pulse on completion of any operation |

## Verification
The main function is driven with single-sector and multi-sector batches, including a repeated sector, to show that erase time scales with distinct sectors and not with command count. An abort, a suspend inside the window and a suspend in the middle of the erase separate the full-time save from the remaining-time save. Reads are scattered over program, chip erase, window, erase and suspension so that the DQ6 and DQ2 toggle rules of each phase are distinguished. Programs with both data polarities, a program into a marked sector and refused erase requests while suspended check the gating of requests.

// File: rtl/flash_erase_timer.sv
module flash_erase_timer #(
  parameter int SECTORS      = 64,
  parameter int TICKS_PER_US = 200,
  parameter int TICKS_PER_MS = 200000,
  parameter int WINDOW_US    = 50,
  parameter int SECT_EXP     = 9,
  parameter int CHIP_EXP     = 12,
  parameter int PROG_TICKS   = 2000,
  parameter int TW           = 48,
  localparam int SW          = $clog2(SECTORS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sec_erase_req,
  input  logic [SW-1:0] req_sector,
  input  logic          chip_erase_req,
  input  logic          prog_req,
  input  logic          prog_bit7,
  input  logic [SW-1:0] prog_sector,
  input  logic          cmd_valid,
  input  logic [7:0]    cmd_byte,
  input  logic [SW-1:0] cmd_sector,
  input  logic          rd_strobe,
  input  logic [SW-1:0] rd_sector,
  output logic [7:0]    status,
  output logic          busy,
  output logic          sector_hit,
  output logic          done
);
  localparam int CW = $clog2(SECTORS + 1);
  localparam logic [TW-1:0] WIN_T  = TW'(64'(WINDOW_US) * 64'(TICKS_PER_US));
  localparam logic [TW-1:0] UNIT_T = TW'((64'd1 << SECT_EXP) * 64'(TICKS_PER_MS));
  localparam logic [TW-1:0] CHIP_T = TW'((64'd1 << CHIP_EXP) * 64'(TICKS_PER_MS));
  localparam logic [TW-1:0] PROG_T = TW'(PROG_TICKS);

  typedef enum logic [2:0] {S_IDLE, S_WIN, S_ERASE, S_CHIP, S_PROG} state_t;

  state_t             st;
  logic [TW-1:0]      cnt, saved;
  logic [SECTORS-1:0] marks;
  logic [CW-1:0]      nsec;
  logic               dq7, dq6, dq3, dq2;

  wire suspended          = saved != '0;
  wire expire             = cnt == TW'(1);
  wire [TW-1:0] erase_len = TW'(nsec) * UNIT_T;
  wire is_resume          = cmd_valid && cmd_byte == 8'h30;
  wire is_suspend         = cmd_valid && cmd_byte == 8'hB0;

  assign status     = {dq7, dq6, 2'b00, dq3, dq2, 2'b00};
  assign busy       = st != S_IDLE;
  assign sector_hit = suspended && st == S_IDLE && marks[rd_sector];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; saved <= '0; marks <= '0; nsec <= '0;
      dq7 <= 1'b0; dq6 <= 1'b0; dq3 <= 1'b0; dq2 <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (rd_strobe) begin
        case (st)
          S_PROG:                 dq6 <= ~dq6;
          S_WIN, S_ERASE, S_CHIP: begin dq6 <= ~dq6; dq2 <= ~dq2; end
          default:                if (suspended && marks[rd_sector]) dq2 <= ~dq2;
        endcase
      end
      case (st)
        S_IDLE: begin
          if (!suspended) begin
            if (sec_erase_req) begin
              marks[req_sector] <= 1'b1; nsec <= CW'(1);
              dq7 <= 1'b0; dq3 <= 1'b0; cnt <= WIN_T; st <= S_WIN;
            end else if (chip_erase_req) begin
              dq7 <= 1'b0; cnt <= CHIP_T; st <= S_CHIP;
            end else if (prog_req) begin
              dq7 <= ~prog_bit7; cnt <= PROG_T; st <= S_PROG;
            end
          end else if (is_resume) begin
            cnt <= saved; saved <= '0; dq7 <= 1'b0; dq3 <= 1'b1; st <= S_ERASE;
          end else if (prog_req && !marks[prog_sector]) begin
            dq7 <= ~prog_bit7; cnt <= PROG_T; st <= S_PROG;
          end
        end
        S_WIN: begin
          if (is_resume) begin
            if (!marks[cmd_sector]) begin
              marks[cmd_sector] <= 1'b1; nsec <= nsec + CW'(1);
            end
            dq7 <= 1'b0; cnt <= WIN_T;
          end else if (is_suspend) begin
            saved <= erase_len; dq3 <= 1'b0; cnt <= '0; st <= S_IDLE;
          end else if (cmd_valid) begin
            marks <= '0; nsec <= '0; dq7 <= 1'b0; dq3 <= 1'b0; cnt <= '0; st <= S_IDLE;
          end else if (expire) begin
            dq3 <= 1'b1; cnt <= erase_len; st <= S_ERASE;
          end else begin
            cnt <= cnt - TW'(1);
          end
        end
        S_ERASE: begin
          if (is_suspend) begin
            saved <= cnt; dq3 <= 1'b0; cnt <= '0; st <= S_IDLE;
          end else if (expire) begin
            marks <= '0; nsec <= '0; dq3 <= 1'b0; dq7 <= ~dq7;
            cnt <= '0; st <= S_IDLE; done <= 1'b1;
          end else begin
            cnt <= cnt - TW'(1);
          end
        end
        S_CHIP, S_PROG: begin
          if (expire) begin
            dq7 <= ~dq7; cnt <= '0; st <= S_IDLE; done <= 1'b1;
          end else begin
            cnt <= cnt - TW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r2_start_window: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !suspended && sec_erase_req) |=> (busy && !status[3] && !status[7]));

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_dq6_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |=> $stable(status[6]));

  a_r9_suspend_idles: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_WIN || st == S_ERASE) && is_suspend) |=> (!busy && suspended && !status[3]));

  a_r10_hit_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    sector_hit |-> !busy);

  a_r12_resume_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && suspended && is_resume) |=> (busy && status[3] && !status[7]));
endmodule

// File: tb/flash_erase_timer_bench.sv
`timescale 1ns/1ps
module flash_erase_timer_bench;
  localparam int NS = 8, SWB = 3;
  localparam int TPU = 1, WUS = 5, TPM = 2, SE = 2, CE = 3, PT = 3;
  localparam int WIN = WUS * TPU, UNIT = (1 << SE) * TPM, CHIP = (1 << CE) * TPM;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic sec_erase_req = 0, chip_erase_req = 0, prog_req = 0, prog_bit7 = 0;
  logic cmd_valid = 0, rd_strobe = 0;
  logic [SWB-1:0] req_sector = 0, prog_sector = 0, cmd_sector = 0, rd_sector = 0;
  logic [7:0] cmd_byte = 0;
  logic [7:0] status;
  logic busy, sector_hit, done;

  flash_erase_timer #(.SECTORS(NS), .TICKS_PER_US(TPU), .TICKS_PER_MS(TPM), .WINDOW_US(WUS),
    .SECT_EXP(SE), .CHIP_EXP(CE), .PROG_TICKS(PT), .TW(16)) u_flash_erase_timer (
    .clk(clk), .rst_n(rst_n), .sec_erase_req(sec_erase_req), .req_sector(req_sector),
    .chip_erase_req(chip_erase_req), .prog_req(prog_req), .prog_bit7(prog_bit7),
    .prog_sector(prog_sector), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .cmd_sector(cmd_sector), .rd_strobe(rd_strobe), .rd_sector(rd_sector),
    .status(status), .busy(busy), .sector_hit(sector_hit), .done(done));

  int total = 0, bad = 0;
  string cur_req = "R1";

  int mode = 0, tmr = 0, saved = 0;
  int q[$];
  bit m7 = 0, m6 = 0, m3 = 0, m2 = 0, mdone = 0;

  function automatic bit has(int s);
    foreach (q[i]) if (q[i] == s) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    int m;
    bit prehit;
    m = mode;
    prehit = saved > 0 && m == 0 && has(int'(rd_sector));
    mdone = 0;
    if (!rst_n) begin
      mode = 0; tmr = 0; saved = 0; q.delete();
      m7 = 0; m6 = 0; m3 = 0; m2 = 0;
      return;
    end
    if (rd_strobe) begin
      if (m == 4) m6 = ~m6;
      else if (m >= 1) begin m6 = ~m6; m2 = ~m2; end
      else if (prehit) m2 = ~m2;
    end
    case (m)
      0: if (saved == 0) begin
           if (sec_erase_req) begin q = '{int'(req_sector)}; m7 = 0; m3 = 0; mode = 1; tmr = WIN; end
           else if (chip_erase_req) begin m7 = 0; mode = 3; tmr = CHIP; end
           else if (prog_req) begin m7 = ~prog_bit7; mode = 4; tmr = PT; end
         end else if (cmd_valid && cmd_byte == 8'h30) begin
           mode = 2; tmr = saved; saved = 0; m7 = 0; m3 = 1;
         end else if (prog_req && !has(int'(prog_sector))) begin
           m7 = ~prog_bit7; mode = 4; tmr = PT;
         end
      1: if (cmd_valid) begin
           if (cmd_byte == 8'h30) begin
             if (!has(int'(cmd_sector))) q.push_back(int'(cmd_sector));
             m7 = 0; tmr = WIN;
           end else if (cmd_byte == 8'hB0) begin
             saved = q.size() * UNIT; m3 = 0; mode = 0;
           end else begin
             q.delete(); m7 = 0; m3 = 0; mode = 0;
           end
         end else if (tmr == 1) begin m3 = 1; mode = 2; tmr = q.size() * UNIT; end
         else tmr--;
      2: if (cmd_valid && cmd_byte == 8'hB0) begin saved = tmr; m3 = 0; mode = 0; end
         else if (tmr == 1) begin q.delete(); m3 = 0; m7 = ~m7; mode = 0; mdone = 1; end
         else tmr--;
      default: if (tmr == 1) begin m7 = ~m7; mode = 0; mdone = 1; end
               else tmr--;
    endcase
  endtask

  always @(posedge clk) begin
    #0.5;
    model_step();
    check(cur_req, "status", int'(status), int'({m7, m6, 2'b00, m3, m2, 2'b00}));
    check(cur_req, "busy", int'(busy), int'(mode != 0));
    check(cur_req, "done", int'(done), int'(mdone));
    check(cur_req, "sector_hit", int'(sector_hit),
          int'(saved > 0 && mode == 0 && has(int'(rd_sector))));
  end

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask
  task automatic do_cmd(logic [7:0] b, int s);
    @(negedge clk); cmd_valid = 1; cmd_byte = b; cmd_sector = SWB'(s);
    @(negedge clk); cmd_valid = 0;
  endtask
  task automatic do_sec(int s);
    @(negedge clk); sec_erase_req = 1; req_sector = SWB'(s);
    @(negedge clk); sec_erase_req = 0;
  endtask
  task automatic do_chip();
    @(negedge clk); chip_erase_req = 1;
    @(negedge clk); chip_erase_req = 0;
  endtask
  task automatic do_prog(bit b7, int s);
    @(negedge clk); prog_req = 1; prog_bit7 = b7; prog_sector = SWB'(s);
    @(negedge clk); prog_req = 0;
  endtask
  task automatic do_rd(int s);
    @(negedge clk); rd_strobe = 1; rd_sector = SWB'(s);
    @(negedge clk); rd_strobe = 0;
  endtask
  task automatic wait_idle();
    for (int i = 0; i < 400 && busy; i++) @(negedge clk);
  endtask

  initial begin
    cyc(3);
    check("R1", "reset status", int'(status), 0);
    check("R1", "reset busy", int'(busy), 0);
    rst_n = 1;
    cyc(2);

    cur_req = "R7";
    do_prog(1'b1, 0);
    check("R7", "dq7 during program", int'(status[7]), 0);
    cur_req = "R8";
    do_rd(0); do_rd(0);
    wait_idle(); cyc(1);
    check("R7", "dq7 after program", int'(status[7]), 1);
    cur_req = "R7";
    do_prog(1'b0, 1); do_rd(1);
    wait_idle(); cyc(1);
    check("R7", "dq7 after program of 0", int'(status[7]), 0);

    cur_req = "R6";
    do_chip();
    check("R6", "chip busy", int'(busy), 1);
    do_rd(2); do_cmd(8'hF0, 0); do_cmd(8'hB0, 0); do_rd(5);
    wait_idle(); cyc(1);
    check("R6", "dq7 after chip erase", int'(status[7]), 1);

    cur_req = "R8";
    do_rd(3); do_rd(3);

    cur_req = "R2";
    do_sec(2);
    check("R2", "window dq3", int'(status[3]), 0);
    cur_req = "R3";
    do_cmd(8'h30, 5); do_rd(2); do_cmd(8'h30, 2);
    cur_req = "R4";
    cyc(WIN + 2);
    check("R4", "erase dq3", int'(status[3]), 1);
    do_cmd(8'hAA, 1); do_cmd(8'h30, 6); do_rd(4);
    cur_req = "R5";
    wait_idle(); cyc(1);
    check("R5", "dq7 after erase", int'(status[7]), 1);

    cur_req = "R3";
    do_sec(1); do_cmd(8'hF0, 0); cyc(1);
    check("R3", "abort busy", int'(busy), 0);

    cur_req = "R9";
    do_sec(3); do_cmd(8'hB0, 0); cyc(1);
    check("R9", "suspend busy", int'(busy), 0);
    cur_req = "R10";
    rd_sector = 3; #0.5;
    check("R10", "hit marked", int'(sector_hit), 1);
    rd_sector = 4; #0.5;
    check("R10", "hit unmarked", int'(sector_hit), 0);
    do_rd(3); do_rd(4);
    cur_req = "R11";
    do_prog(1'b0, 3); cyc(1);
    check("R11", "dropped program busy", int'(busy), 0);
    do_sec(5); do_chip(); cyc(1);
    check("R11", "refused erase busy", int'(busy), 0);
    do_prog(1'b0, 4); wait_idle(); cyc(1);
    cur_req = "R12";
    do_cmd(8'h30, 0);
    check("R12", "resume busy", int'(busy), 1);
    wait_idle(); cyc(2);

    cur_req = "R9";
    do_sec(6); do_cmd(8'h30, 7);
    cyc(WIN + 4);
    do_cmd(8'hB0, 0); cyc(2);
    cur_req = "R12";
    do_cmd(8'h30, 0);
    wait_idle(); cyc(3);
    check("R5", "final idle", int'(busy), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule